// File: doc/BRIEF.md
# Triggered Programmable Delay Block

This block turns a rising trigger edge into precisely timed strobes for scheduling conversions. One trigger source is chosen, either an internal one or an external one. A rising edge on it starts an up-counter that runs from zero to a programmable modulo. Two delay channels compare the count against their own programmed values. Each channel gives a one-cycle strobe when the count matches.

The two strobes can be combined into a single conversion request, so that one trigger schedules two conversions. The same strobes also set and clear a window output, so the placement of both window edges is fixed relative to the trigger. The counter can stop after one pass and wait for the next edge, or it can wrap and repeat without limit. A bypass setting sends the trigger edge straight to the strobes without counting. All controls are plain level inputs, meant to be driven by a register bank outside the block.

Top module: `trig_delay_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, all outputs are low after that edge, and the counter is idle.
- R2: With `trig_sel`=0 and `enable`=1, the first clock edge that samples `trig_int` high after it was low starts the count. `dly_pulse[i]` is then high for exactly one cycle, starting at the clock edge that comes D_i+1 edges after the starting edge (D_0=`delay0`, D_1=`delay1`).
- R3: With `trig_sel`=1, `trig_ext` passes through a two-flip-flop synchroniser before edge detection. Every result of R2 therefore comes two cycles later, counted from the edge that first samples `trig_ext` high.
- R4: A channel whose delay is greater than `modulo` never pulses.
- R5: `conv_req` is high in the cycles where `dly_pulse[0]` is high. When `or_en`=1 it is also high in the cycles where `dly_pulse[1]` is high.
- R6: `window` goes high in the cycle in which `dly_pulse[0]` is high and goes low in the cycle in which `dly_pulse[1]` is high. When both are high in the same cycle, `window` is low.
- R7: With `cont_mode`=0 the counter stops after it reaches `modulo` and gives no more pulses. A later rising trigger edge starts a fresh pass.
- R8: A rising trigger edge that arrives while a count is in progress is ignored.
- R9: With `cont_mode`=1 the count wraps from `modulo` to zero, so each channel pulses once every `modulo`+1 cycles.
- R10: With `bypass`=1 there is no counting. One cycle after the detected edge, both `dly_pulse` bits and `conv_req` are high for one cycle, and `window` follows the selected trigger level one cycle later.
- R11: When `enable` is sampled low, the counter is cleared and all outputs, including `done`, are low after that edge. Trigger edges are ignored while `enable` is low.
- R12: `done` rises M+1 edges after the starting edge, where M is `modulo`. It stays high until `done_clr` is sampled high. If a new terminal count arrives in the same cycle, the set takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low clears counter and outputs |
| trig_sel | input | 1 | Trigger source: 0 internal, 1 external |
| trig_int | input | 1 | Internal trigger, synchronous to clk |
| trig_ext | input | 1 | External trigger, asynchronous |
| cont_mode | input | 1 | 1 wraps and repeats, 0 stops after one pass |
| bypass | input | 1 | 1 routes the trigger edge straight to outputs |
| or_en | input | 1 | 1 merges channel 1 strobes into conv_req |
| done_clr | input | 1 | Clears the done flag |
| modulo | input | 16 | Terminal count |
| delay0 | input | 16 | Channel 0 delay; also window set point |
| delay1 | input | 16 | Channel 1 delay; also window clear point |
| dly_pulse | output | 2 | One-cycle strobe per channel |
| conv_req | output | 1 | Combined conversion request |
| window | output | 1 | Window gated by the two channels |
| done | output | 1 | Sticky terminal-count flag |

## Verification
Take the edge that first samples an internal trigger high as edge 1. A channel with delay D pulses after edge D+2 and `done` rises after edge M+2. In continuous mode the pulses repeat every M+1 edges. On the external path the same results come two edges later. In bypass the strobes come after edge 1, and an `enable` or `done_clr` change takes effect at the next edge. The bench drives and samples on the falling edge and counts edges from the trigger. For each vector it computes the expected outputs from these formulas and compares them every cycle, so a result one cycle early or late is reported.

// File: rtl/tdg_pkg.sv
// Shared types for the triggered delay generator.
// Assumes: consumers import the package; no state lives here.
package tdg_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } trig_src_e;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/tdg_trig_front.sv
// Trigger front end: synchronises the external trigger, selects the source
// and produces a one-cycle rising-edge strobe.
// Assumes: trig_int is already synchronous to clk; SYNC_STAGES >= 2.
module tdg_trig_front
    import tdg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_sel,
    input  logic trig_int,
    input  logic trig_ext,
    output logic trig_lvl,
    output logic trig_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the asynchronous external trigger through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_ext};
        end
    end

    // Pick the active trigger source.
    always_comb begin
        if (trig_src_e'(trig_sel) == SRC_EXTERNAL) begin
            trig_lvl = sync_q[SYNC_STAGES-1];
        end else begin
            trig_lvl = trig_int;
        end
    end

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= trig_lvl;
        end
    end

    // Rising edge strobe.
    assign trig_rise = trig_lvl & ~prev_q;

endmodule

// File: rtl/tdg_counter.sv
// Delay counter: starts from zero on a start strobe when idle, runs to the
// modulo, then stops (single pass) or wraps (continuous). Holds the sticky
// done flag.
// Assumes: start is a single-cycle strobe; modulo is stable during a pass.
module tdg_counter
    import tdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bypass,
    input  logic             cont_mode,
    input  logic             start,
    input  logic             done_clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             at_mod;

    // Terminal count reached during a pass.
    assign at_mod = (state_q == CNT_RUN) && (cnt_q == modulo);

    // Count sequencing: idle/run state and the count value.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || bypass) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                CNT_IDLE: begin
                    if (start) begin
                        state_q <= CNT_RUN;
                        cnt_q   <= '0;
                    end
                end
                CNT_RUN: begin
                    if (at_mod) begin
                        cnt_q <= '0;
                        if (!cont_mode) begin
                            state_q <= CNT_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: begin
                    state_q <= CNT_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Sticky done flag; a new terminal count beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            done_q <= 1'b0;
        end else if (at_mod) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    assign cnt    = cnt_q;
    assign active = (state_q == CNT_RUN);
    assign done   = done_q;

endmodule

// File: rtl/tdg_match.sv
// One delay channel comparator: flags the cycle in which the running count
// equals the channel delay.
// Assumes: cnt never exceeds modulo, so a delay above modulo never matches.
module tdg_match #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             active,
    input  logic [CNT_W-1:0] delay,
    output logic             hit
);

    // Compare only while a pass is in progress.
    assign hit = active && (cnt == delay);

endmodule

// File: rtl/trig_delay_gen.sv
// Top of the triggered delay generator: front end, counter, two delay
// channels and registered outputs (channel strobes, merged request, window).
// Assumes: control inputs come from a register bank in the clk domain,
// except trig_ext, which may be asynchronous.
module trig_delay_gen
    import tdg_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig_sel,
    input  logic             trig_int,
    input  logic             trig_ext,
    input  logic             cont_mode,
    input  logic             bypass,
    input  logic             or_en,
    input  logic             done_clr,
    input  logic [CNT_W-1:0] modulo,
    input  logic [CNT_W-1:0] delay0,
    input  logic [CNT_W-1:0] delay1,
    output logic [1:0]       dly_pulse,
    output logic             conv_req,
    output logic             window,
    output logic             done
);

    localparam int N_CH = 2;

    logic             trig_lvl;
    logic             trig_rise;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic [CNT_W-1:0] delays [N_CH];
    logic [N_CH-1:0]  hit;
    logic [N_CH-1:0]  pulse_q;
    logic             conv_q;
    logic             win_q;

    assign delays[0] = delay0;
    assign delays[1] = delay1;

    tdg_trig_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_sel (trig_sel),
        .trig_int (trig_int),
        .trig_ext (trig_ext),
        .trig_lvl (trig_lvl),
        .trig_rise(trig_rise)
    );

    tdg_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .bypass   (bypass),
        .cont_mode(cont_mode),
        .start    (trig_rise),
        .done_clr (done_clr),
        .modulo   (modulo),
        .cnt      (cnt),
        .active   (active),
        .done     (done)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        tdg_match #(
            .CNT_W(CNT_W)
        ) u_match (
            .cnt   (cnt),
            .active(active),
            .delay (delays[ch]),
            .hit   (hit[ch])
        );
    end

    // Output registers: delayed strobes, or bypassed edge, plus window.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pulse_q <= '0;
            conv_q  <= 1'b0;
            win_q   <= 1'b0;
        end else if (bypass) begin
            pulse_q <= {N_CH{trig_rise}};
            conv_q  <= trig_rise;
            win_q   <= trig_lvl;
        end else begin
            pulse_q <= hit;
            conv_q  <= hit[0] | (or_en & hit[1]);
            if (hit[1]) begin
                win_q <= 1'b0;
            end else if (hit[0]) begin
                win_q <= 1'b1;
            end
        end
    end

    assign dly_pulse = pulse_q;
    assign conv_req  = conv_q;
    assign window    = win_q;

endmodule

// File: rtl/tdg_checker.sv
// Property checker for trig_delay_gen, attached by bind.
// Assumes: observes top-level ports only.
module tdg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             bypass,
    input logic             or_en,
    input logic             done_clr,
    input logic [CNT_W-1:0] modulo,
    input logic [CNT_W-1:0] delay0,
    input logic [1:0]       dly_pulse,
    input logic             conv_req,
    input logic             window,
    input logic             done
);

    // R2 / R10: a channel strobe lasts a single cycle when the period exceeds one.
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_pulse[0] && modulo != '0 && $stable(modulo) && $stable(bypass))
        |=> !dly_pulse[0]);

    // R4: channel 0 only fires when its delay was within the modulo.
    p_no_fire_beyond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_pulse[0] && !$past(bypass)) |-> ($past(delay0) <= $past(modulo)));

    // R5: the merged request matches the channel strobes.
    p_conv_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req == (dly_pulse[0] || ($past(or_en) && dly_pulse[1])));

    // R11: a low enable leaves every output low.
    p_disable_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dly_pulse == 2'b00 && !conv_req && !window && !done));

    // R12: done holds until cleared.
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr && enable) |=> done);

endmodule

bind trig_delay_gen tdg_checker #(.CNT_W(CNT_W)) u_tdg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .bypass   (bypass),
    .or_en    (or_en),
    .done_clr (done_clr),
    .modulo   (modulo),
    .delay0   (delay0),
    .dly_pulse(dly_pulse),
    .conv_req (conv_req),
    .window   (window),
    .done     (done)
);

// File: tb/trig_delay_gen_tb_top.sv
`timescale 1ns/1ps
module trig_delay_gen_tb_top;

    typedef struct packed {
        logic [15:0] m;
        logic [15:0] d0;
        logic [15:0] d1;
        logic        orr;
        logic        cont;
        logic        ext;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd8, 16'd2, 16'd5,  1'b1, 1'b0, 1'b0},
        '{16'd8, 16'd2, 16'd5,  1'b0, 1'b0, 1'b0},
        '{16'd6, 16'd3, 16'd20, 1'b1, 1'b0, 1'b0},
        '{16'd5, 16'd1, 16'd4,  1'b1, 1'b1, 1'b0},
        '{16'd7, 16'd0, 16'd7,  1'b1, 1'b0, 1'b1},
        '{16'd4, 16'd3, 16'd3,  1'b1, 1'b1, 1'b1},
        '{16'd9, 16'd6, 16'd2,  1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n, enable, trig_sel, trig_int, trig_ext;
    logic        cont_mode, bypass, or_en, done_clr;
    logic [15:0] modulo, delay0, delay1;
    logic [1:0]  dly_pulse;
    logic        conv_req, window, done;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    trig_delay_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_sel(trig_sel),
        .trig_int(trig_int), .trig_ext(trig_ext), .cont_mode(cont_mode),
        .bypass(bypass), .or_en(or_en), .done_clr(done_clr),
        .modulo(modulo), .delay0(delay0), .delay1(delay1),
        .dly_pulse(dly_pulse), .conv_req(conv_req), .window(window), .done(done)
    );

    // Compare {dly_pulse, conv_req, window, done} against an expected value.
    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {dly_pulse, conv_req, window, done};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b (pulse1 pulse0 conv window done)",
                     tag, got, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; trig_sel = 1'b0; trig_int = 1'b1;
        trig_ext = 1'b0; cont_mode = 1'b0; bypass = 1'b0; or_en = 1'b1;
        done_clr = 1'b0; modulo = 16'd3; delay0 = 16'd0; delay1 = 16'd1;
        repeat (4) idle_cycle();
        chk("R1 reset state", 5'b00000);
        trig_int = 1'b0;
        idle_cycle();
        rst_n = 1'b1;
        idle_cycle();
        chk("R1 after release", 5'b00000);

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R12.
        for (int v = 0; v < NV; v++) begin
            int m, d0, d1, off, len;
            logic w;
            enable = 1'b0; trig_int = 1'b0; trig_ext = 1'b0;
            modulo = VECS[v].m; delay0 = VECS[v].d0; delay1 = VECS[v].d1;
            or_en = VECS[v].orr; cont_mode = VECS[v].cont; trig_sel = VECS[v].ext;
            repeat (3) idle_cycle();
            enable = 1'b1;
            idle_cycle();
            m = VECS[v].m; d0 = VECS[v].d0; d1 = VECS[v].d1;
            off = VECS[v].ext ? 2 : 0;
            len = VECS[v].cont ? 3 * (m + 1) + 6 : m + 8;
            w = 1'b0;
            if (VECS[v].ext) trig_ext = 1'b1; else trig_int = 1'b1;
            for (int j = 1; j <= len; j++) begin
                int e;
                logic p0, p1, cv, dn;
                idle_cycle();
                e = j - off;
                if (VECS[v].cont) begin
                    p0 = (d0 <= m) && (e >= 2) && (((e - 2) % (m + 1)) == d0);
                    p1 = (d1 <= m) && (e >= 2) && (((e - 2) % (m + 1)) == d1);
                end else begin
                    p0 = (d0 <= m) && (e == d0 + 2);
                    p1 = (d1 <= m) && (e == d1 + 2);
                end
                if (p1) w = 1'b0; else if (p0) w = 1'b1;
                cv = p0 | (VECS[v].orr & p1);
                dn = (e >= m + 2);
                chk($sformatf("vec %0d cycle %0d R2 R3 R4 R5 R6 R7 R9 R12", v, j),
                    {p1, p0, cv, w, dn});
            end
        end

        // R8: edge during a single pass is ignored; R7: restart afterwards.
        enable = 1'b0; trig_int = 1'b0; trig_sel = 1'b0; trig_ext = 1'b0;
        cont_mode = 1'b0; modulo = 16'd10; delay0 = 16'd6; delay1 = 16'd20;
        or_en = 1'b0;
        repeat (2) idle_cycle();
        enable = 1'b1;
        idle_cycle();
        trig_int = 1'b1;
        for (int j = 1; j <= 16; j++) begin
            idle_cycle();
            if (j == 2) trig_int = 1'b0;
            if (j == 4) trig_int = 1'b1;
            chk($sformatf("R8 retrigger ignored cycle %0d", j),
                {1'b0, j == 8, j == 8, j >= 8, j >= 12});
        end
        trig_int = 1'b0;
        idle_cycle();
        trig_int = 1'b1;
        for (int j = 1; j <= 9; j++) begin
            idle_cycle();
            chk($sformatf("R7 restart cycle %0d", j),
                {1'b0, j == 8, j == 8, 1'b1, 1'b1});
        end

        // R12: done stays until cleared, then drops at the next edge.
        repeat (5) idle_cycle();
        chk("R12 done sticky", 5'b00011);
        done_clr = 1'b1;
        idle_cycle();
        done_clr = 1'b0;
        chk("R12 done cleared", 5'b00010);

        // R10: bypass passes the edge straight through.
        enable = 1'b0; trig_int = 1'b0; bypass = 1'b1; or_en = 1'b0;
        repeat (2) idle_cycle();
        enable = 1'b1;
        idle_cycle();
        trig_int = 1'b1;
        idle_cycle();
        chk("R10 bypass strobe", 5'b11110);
        idle_cycle();
        chk("R10 bypass strobe ends", 5'b00010);
        trig_int = 1'b0;
        idle_cycle();
        chk("R10 bypass window follows level", 5'b00000);
        bypass = 1'b0;

        // R11: enable low clears everything and ignores triggers.
        cont_mode = 1'b1; modulo = 16'd3; delay0 = 16'd0; delay1 = 16'd2;
        or_en = 1'b1;
        idle_cycle();
        trig_int = 1'b1;
        repeat (9) idle_cycle();
        enable = 1'b0;
        idle_cycle();
        chk("R11 disable clears", 5'b00000);
        trig_int = 1'b0;
        idle_cycle();
        trig_int = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            idle_cycle();
            chk($sformatf("R11 trigger ignored while disabled %0d", j), 5'b00000);
        end
        trig_int = 1'b0;
        enable = 1'b1;
        idle_cycle();
        trig_int = 1'b1;
        for (int j = 1; j <= 2; j++) begin
            idle_cycle();
            chk($sformatf("R11 fresh count from zero %0d", j),
                {1'b0, j == 2, j == 2, j == 2, 1'b0});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule